// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges every reset request of a small microcontroller into one chip-wide active-low reset. Four requests come from inside the chip: power-on, watchdog expiry, illegal-address detection and low-voltage detection. One comes from outside, through a bidirectional active-low reset pad. On power-up the block also holds reset for an oscillator settling window. A static strap picks whether that window is 224 or 4064 clock cycles.

Reset asserts as soon as any request appears, and the power-on request clears all internal state asynchronously. Release is synchronous to the clock and waits until every request has gone away. The watchdog and low-voltage requests also pull the pad low through an open-drain enable, so that parts outside the chip see the reset too. The block ignores its own low drive when it reads the pad back. When an episode ends and the episode contained an external, watchdog or low-voltage request, the block raises a one-cycle pulse that tells the device to sample its operating mode again. Episodes caused only by power-on or an illegal address end without that pulse.

Top module: `mcu_reset_ctrl`

## Requirements
- R1: While `pwr_on_req` is high, `sys_rst_n` is 0 with no clock edge needed, `mode_resample` is 0, and all internal state returns to its idle value.
- R2: After `pwr_on_req` falls, `sys_rst_n` stays 0 for N rising clock edges and reads 1 right after edge N. N is 224 when `cfg_long_settle` is 0 and 4064 when it is 1.
- R3: If another request is still active when the settling window ends, `sys_rst_n` stays 0 until the last active request has ended.
- R4: Raising `pwr_on_req` again during the settling window restarts the full window, and `sys_rst_n` does not go high at any point in between.
- R5: A watchdog (when enabled), illegal-address or low-voltage request drives `sys_rst_n` to 0 combinationally. If the request was held across at least one edge, `sys_rst_n` reads 1 right after the first edge at which the request is low (provided no other source is active).
- R6: `rst_pin_in` passes through a two-flop synchronizer. A pad held low pulls `sys_rst_n` to 0 after the second edge. After the pad returns high, `sys_rst_n` reads 1 after the third edge.
- R7: `rst_pin_drive` (1 means pull the pad low) is 1 exactly while `low_volt_req` is 1, or while `wdog_req` and `cfg_wdog_en` are both 1. It is never 1 for power-on, illegal-address or external requests.
- R8: The pad going low because of the block's own drive does not count as an external request, including during the synchronizer latency after the drive ends. `sys_rst_n` therefore releases as in R5.
- R9: With `cfg_wdog_en` at 0, `wdog_req` has no effect on `sys_rst_n`, `rst_pin_drive` or `mode_resample`.
- R10: `mode_resample` is high for exactly one cycle, starting at the edge where reset releases, when the episode included an external, enabled-watchdog or low-voltage request.
- R11: An episode that included only power-on and/or illegal-address requests ends with `mode_resample` staying 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| pwr_on_req | input | 1 | Power-on request, active high, asynchronous |
| wdog_req | input | 1 | Watchdog expiry request, active high |
| bad_addr_req | input | 1 | Illegal-address request, active high |
| low_volt_req | input | 1 | Low-voltage request, active high |
| cfg_wdog_en | input | 1 | Static strap: 1 enables the watchdog source |
| cfg_long_settle | input | 1 | Static strap: 0 selects 224 cycles, 1 selects 4064 cycles |
| rst_pin_in | input | 1 | Level read back from the active-low reset pad |
| rst_pin_drive | output | 1 | Open-drain enable; 1 pulls the pad low |
| sys_rst_n | output | 1 | Combined chip reset, active low |
| mode_resample | output | 1 | One-cycle pulse: sample the operating mode again |

## Verification
The hardest case to reach from the ports is the release of a low-voltage or watchdog episode. At that moment the pad is still rising through the synchronizer, and a stale low sample could start a second, false external episode. The stimulus models the pad as a wired AND of the bench's own drive and the block's drive. It then ends such episodes and checks that reset stays released during the following synchronizer cycles. A second hard case is a request that outlives the settling window or a power-on request that comes back during the window. The bench times these against the window length so that both fall in the middle of a count.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    // State that follows one reset episode from start to release
    typedef struct packed {
        logic hold;     // combined reset held in a register
        logic qual;     // a mode-changing source was seen in this episode
        logic pulse;    // mode re-sample strobe
    } rstc_epi_t;

    localparam rstc_epi_t EPI_IDLE = '{hold: 1'b1, qual: 1'b0, pulse: 1'b0};

    function automatic int unsigned settle_len(input logic long_sel,
                                               input int unsigned short_len,
                                               input int unsigned long_len);
        return long_sel ? long_len : short_len;
    endfunction

endpackage

// File: rtl/rstc_pin_sync.sv
module rstc_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic arst,
    input  logic pin_in,
    input  logic drive_lo,
    output logic ext_req
);

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic [STAGES-1:0] blank;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.sync  = {st_q.sync[STAGES-2:0], pin_in};
        st_d.blank = {st_q.blank[STAGES-2:0], drive_lo};
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            st_q.sync  <= '1;
            st_q.blank <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // A low pad level counts only when our own drive cannot explain it
    assign ext_req = ~st_q.sync[STAGES-1] & ~drive_lo & ~(|st_q.blank);

endmodule

// File: rtl/rstc_por_timer.sv
module rstc_por_timer #(
    parameter int unsigned SHORT_CYC = 224,
    parameter int unsigned LONG_CYC  = 4064
) (
    input  logic clk,
    input  logic arst,
    input  logic long_sel,
    output logic busy
);
    import rstc_pkg::*;

    localparam int unsigned CW = $clog2(LONG_CYC);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] last;

    always_comb begin
        last  = CW'(settle_len(long_sel, SHORT_CYC, LONG_CYC) - 1);
        busy  = (cnt_q < last);
        cnt_d = cnt_q;
        if (busy) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/rstc_episode.sv
module rstc_episode (
    input  logic clk,
    input  logic arst,
    input  logic src_active,
    input  logic qual_now,
    output logic hold,
    output logic pulse
);
    import rstc_pkg::*;

    rstc_epi_t epi_d, epi_q;

    always_comb begin
        epi_d       = epi_q;
        epi_d.hold  = src_active;
        epi_d.qual  = src_active & (epi_q.qual | qual_now);
        epi_d.pulse = epi_q.hold & ~src_active & (epi_q.qual | qual_now);
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            epi_q <= EPI_IDLE;
        end else begin
            epi_q <= epi_d;
        end
    end

    assign hold  = epi_q.hold;
    assign pulse = epi_q.pulse;

endmodule

// File: rtl/mcu_reset_ctrl.sv
module mcu_reset_ctrl #(
    parameter int unsigned SHORT_CYC   = 224,
    parameter int unsigned LONG_CYC    = 4064,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic pwr_on_req,
    input  logic wdog_req,
    input  logic bad_addr_req,
    input  logic low_volt_req,
    input  logic cfg_wdog_en,
    input  logic cfg_long_settle,
    input  logic rst_pin_in,
    output logic rst_pin_drive,
    output logic sys_rst_n,
    output logic mode_resample
);

    logic settle_busy;
    logic ext_req;
    logic wdog_live;
    logic src_active;
    logic qual_now;
    logic hold;

    rstc_por_timer #(
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC)
    ) u_timer (
        .clk      (clk),
        .arst     (pwr_on_req),
        .long_sel (cfg_long_settle),
        .busy     (settle_busy)
    );

    rstc_pin_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .arst     (pwr_on_req),
        .pin_in   (rst_pin_in),
        .drive_lo (rst_pin_drive),
        .ext_req  (ext_req)
    );

    always_comb begin
        wdog_live     = cfg_wdog_en & wdog_req;
        rst_pin_drive = low_volt_req | wdog_live;
        qual_now      = ext_req | wdog_live | low_volt_req;
        src_active    = settle_busy | bad_addr_req | qual_now;
    end

    rstc_episode u_epi (
        .clk        (clk),
        .arst       (pwr_on_req),
        .src_active (src_active),
        .qual_now   (qual_now),
        .hold       (hold),
        .pulse      (mode_resample)
    );

    assign sys_rst_n = ~(hold | src_active);

endmodule

// File: rtl/rstc_checker.sv
module rstc_checker (
    input logic clk,
    input logic pwr_on_req,
    input logic wdog_req,
    input logic bad_addr_req,
    input logic low_volt_req,
    input logic cfg_wdog_en,
    input logic cfg_long_settle,
    input logic rst_pin_in,
    input logic rst_pin_drive,
    input logic sys_rst_n,
    input logic mode_resample
);

    p_por_forces_reset_r1: assert property (@(posedge clk)
        pwr_on_req |-> !sys_rst_n);

    p_no_strobe_in_por_r11: assert property (@(posedge clk)
        pwr_on_req |-> !mode_resample);

    p_source_holds_reset_r5: assert property (@(posedge clk) disable iff (pwr_on_req)
        (bad_addr_req || low_volt_req) |-> !sys_rst_n);

    p_drive_implies_reset_r7: assert property (@(posedge clk) disable iff (pwr_on_req)
        rst_pin_drive |-> !sys_rst_n);

    p_wdog_off_no_drive_r9: assert property (@(posedge clk) disable iff (pwr_on_req)
        (!cfg_wdog_en && !low_volt_req) |-> !rst_pin_drive);

    p_strobe_single_r10: assert property (@(posedge clk) disable iff (pwr_on_req)
        mode_resample |=> !mode_resample);

    p_strobe_follows_reset_r10: assert property (@(posedge clk) disable iff (pwr_on_req)
        mode_resample |-> $past(!sys_rst_n));

endmodule

bind mcu_reset_ctrl rstc_checker u_chk (.*);

// File: tb/sim_mcu_reset_ctrl.sv
module sim_mcu_reset_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int SHORT      = 224;
    localparam int LONG       = 4064;
    localparam int MAX_CYC    = 200000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic pwr_on_req      = 1'b1;
    logic wdog_req        = 1'b0;
    logic bad_addr_req    = 1'b0;
    logic low_volt_req    = 1'b0;
    logic cfg_wdog_en     = 1'b1;
    logic cfg_long_settle = 1'b0;
    logic ext_drv_n       = 1'b1;
    logic rst_pin_in;
    logic rst_pin_drive;
    logic sys_rst_n;
    logic mode_resample;

    // wired-AND pad: bench pulls low via ext_drv_n, block via rst_pin_drive
    assign rst_pin_in = ext_drv_n & ~rst_pin_drive;

    mcu_reset_ctrl u0 (
        .clk             (clk),
        .pwr_on_req      (pwr_on_req),
        .wdog_req        (wdog_req),
        .bad_addr_req    (bad_addr_req),
        .low_volt_req    (low_volt_req),
        .cfg_wdog_en     (cfg_wdog_en),
        .cfg_long_settle (cfg_long_settle),
        .rst_pin_in      (rst_pin_in),
        .rst_pin_drive   (rst_pin_drive),
        .sys_rst_n       (sys_rst_n),
        .mode_resample   (mode_resample)
    );

    typedef struct {
        int    cyc;
        logic  rst_n;
        logic  drive;
        logic  pulse;
        string tag;
    } exp_t;

    exp_t sb[$];
    int   cyc    = 0;
    int   checks = 0;
    int   fails  = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic judge(input string tag, input logic r, input logic o, input logic p);
        checks++;
        if (sys_rst_n !== r || rst_pin_drive !== o || mode_resample !== p) begin
            fails++;
            $display("FAIL %s @cyc %0d: got rst_n=%b drive=%b pulse=%b, expected %b %b %b",
                     tag, cyc, sys_rst_n, rst_pin_drive, mode_resample, r, o, p);
        end
    endtask

    // scoreboard monitor: compares due items at each falling edge
    always @(negedge clk) begin
        exp_t e;
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            e = sb.pop_front();
            if (e.cyc != cyc) begin
                checks++;
                fails++;
                $display("FAIL %s: item for cyc %0d missed, now %0d", e.tag, e.cyc, cyc);
            end else begin
                judge(e.tag, e.rst_n, e.drive, e.pulse);
            end
        end
    end

    task automatic expect_at(input int dc, input logic r, input logic o, input logic p,
                             input string tag);
        exp_t item;
        int   i;
        item = '{cyc + dc, r, o, p, tag};
        i = sb.size();
        while (i > 0 && sb[i-1].cyc > item.cyc) i--;
        sb.insert(i, item);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        tick(3);
        judge("R1 reset state during power-on", 1'b0, 1'b0, 1'b0);
        tick(2);

        // R2 short settling window, R11 no strobe after power-on
        pwr_on_req = 1'b0;
        expect_at(SHORT-1, 1'b0, 1'b0, 1'b0, "R2 short window still held");
        expect_at(SHORT,   1'b1, 1'b0, 1'b0, "R2 short window released; R11 no strobe");
        expect_at(SHORT+1, 1'b1, 1'b0, 1'b0, "R11 still no strobe");
        tick(SHORT+3);

        // R1 asynchronous assertion, R4 restart of the window
        pwr_on_req = 1'b1;
        #1;
        judge("R1 asynchronous assertion", 1'b0, 1'b0, 1'b0);
        tick(2);
        pwr_on_req = 1'b0;
        tick(100);
        pwr_on_req = 1'b1;
        expect_at(1, 1'b0, 1'b0, 1'b0, "R4 held while re-requested");
        tick(3);
        pwr_on_req = 1'b0;
        for (int k = 1; k < SHORT; k += 37) expect_at(k, 1'b0, 1'b0, 1'b0, "R4 no glitch");
        expect_at(SHORT-1, 1'b0, 1'b0, 1'b0, "R4 full window after restart");
        expect_at(SHORT,   1'b1, 1'b0, 1'b0, "R4 release after restart");
        tick(SHORT+3);

        // R3 low-voltage outlives the window
        pwr_on_req = 1'b1;
        tick(2);
        pwr_on_req = 1'b0;
        expect_at(SHORT, 1'b0, 1'b1, 1'b0, "R3 held past window");
        tick(200);
        low_volt_req = 1'b1;
        expect_at(1, 1'b0, 1'b1, 1'b0, "R7 pad driven for low-voltage");
        tick(100);
        low_volt_req = 1'b0;
        expect_at(1, 1'b1, 1'b0, 1'b1, "R3 release after last source; R10 strobe");
        expect_at(2, 1'b1, 1'b0, 1'b0, "R10 strobe lasts one cycle");
        expect_at(3, 1'b1, 1'b0, 1'b0, "R8 own drive not seen as external");
        expect_at(4, 1'b1, 1'b0, 1'b0, "R8 stays released");
        tick(6);

        // R5 illegal address, R11 no strobe
        bad_addr_req = 1'b1;
        expect_at(1, 1'b0, 1'b0, 1'b0, "R5 illegal-address reset; R7 no drive");
        tick(5);
        bad_addr_req = 1'b0;
        expect_at(1, 1'b1, 1'b0, 1'b0, "R5 release; R11 no strobe");
        expect_at(2, 1'b1, 1'b0, 1'b0, "R11 no late strobe");
        tick(4);

        // R9 disabled watchdog
        cfg_wdog_en = 1'b0;
        tick(1);
        wdog_req = 1'b1;
        expect_at(1, 1'b1, 1'b0, 1'b0, "R9 disabled watchdog ignored");
        expect_at(4, 1'b1, 1'b0, 1'b0, "R9 still ignored");
        tick(5);
        wdog_req = 1'b0;
        expect_at(1, 1'b1, 1'b0, 1'b0, "R9 no strobe");
        tick(3);

        // R5/R7/R10 enabled watchdog
        cfg_wdog_en = 1'b1;
        tick(2);
        wdog_req = 1'b1;
        expect_at(1, 1'b0, 1'b1, 1'b0, "R7 watchdog drives pad; R5 reset");
        tick(4);
        wdog_req = 1'b0;
        expect_at(1, 1'b1, 1'b0, 1'b1, "R10 strobe after watchdog");
        expect_at(2, 1'b1, 1'b0, 1'b0, "R10 single strobe");
        expect_at(3, 1'b1, 1'b0, 1'b0, "R8 watchdog drive not external");
        tick(6);

        // R6 external pad
        ext_drv_n = 1'b0;
        expect_at(1, 1'b1, 1'b0, 1'b0, "R6 not yet synchronized");
        expect_at(2, 1'b0, 1'b0, 1'b0, "R6 asserted after two flops");
        tick(10);
        ext_drv_n = 1'b1;
        expect_at(2, 1'b0, 1'b0, 1'b0, "R6 held through sync latency");
        expect_at(3, 1'b1, 1'b0, 1'b1, "R6 release; R10 strobe after external");
        expect_at(4, 1'b1, 1'b0, 1'b0, "R10 single strobe");
        tick(8);

        // R2 long settling window
        pwr_on_req      = 1'b1;
        cfg_long_settle = 1'b1;
        tick(2);
        pwr_on_req = 1'b0;
        expect_at(LONG-1, 1'b0, 1'b0, 1'b0, "R2 long window still held");
        expect_at(LONG,   1'b1, 1'b0, 1'b0, "R2 long window released");
        tick(LONG+3);

        tick(5);
        if (sb.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run hung at cyc %0d, expected end before %0d", cyc, MAX_CYC);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule